// File: doc/BRIEF.md
# Multi-link synchronization request combiner

This block sits on the receive side of a multi-link serial converter interface. Each per-link receiver raises an active-low synchronization request. The block turns these requests into one active-low SYNC output per link, driven back toward the transmitters.

A configuration input selects one of two modes:

- **Combined mode:** a request from any link pulls every output low, so that all transmitters resend comma characters and later begin their alignment sequences together.
- **Per-link mode:** each output mirrors only its own receiver.

When the system runs without deterministic latency, a second configuration input forces combined mode.

All outputs are registered on the launch clock and change only on the clock edge that carries the frame-boundary strobe. The launch clock is the frame clock or the device clock, whichever is faster. Because of this, every release happens on a frame boundary, and in combined mode it happens on the same edge for every output.

A request that lasts a given number of frames reaches the output as a low pulse of exactly that many frames. A two-frame error report therefore stays a two-frame pulse, and a held reinitialization request keeps the output low for as long as it lasts.

The mode, force and link-enable inputs are captured only while every output is low, and reset also leaves every output low. A configuration change therefore can never create a glitch on an output that is high.

Top module: `sync_req_combiner`

## Requirements
- R1: Logic 0 means a request on both the inputs and the outputs. Reset drives every output low, and the outputs stay low until a frame-boundary edge samples the inputs.
- R2: Outputs change only on a clock edge at which the frame-boundary strobe is high. When the parameter LAUNCH_ON_FRAME is 1, every edge counts as a boundary.
- R3: In combined mode, if any enabled input is low at a boundary edge, every output is low after that edge.
- R4: In combined mode, once every enabled input is high at a boundary edge, all outputs go high together on that same edge.
- R5: In per-link mode, output i takes the value of input i sampled at each boundary edge, and no other input affects it.
- R6: While the captured no-deterministic-latency input is 1, the block behaves in combined mode whatever the mode select says.
- R7: Mode, force and enable inputs are captured on clock edges where all outputs are low (which includes the state after reset). While any output is high, changes on these inputs are ignored.
- R8: A link whose enable bit is 0 never makes a request. In per-link mode its output goes high at the next boundary edge.
- R9: An input held low for k frames gives an output low for exactly k frames. A two-frame error pulse is not lengthened, and a request of four or more frames holds the output low for its whole length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Launch clock (the faster of the frame clock and the device clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe marking a frame boundary |
| mode_comb | input | 1 | 1 selects combined mode, 0 selects per-link mode |
| no_dl | input | 1 | 1 when deterministic latency is not used; forces combined mode |
| link_en | input | N_LINKS | Per-link enable; 0 removes that link's request |
| link_req_n | input | N_LINKS | Active-low requests from the per-link receivers |
| sync_n | output | N_LINKS | Active-low SYNC outputs toward the transmitters |

## Verification
The following properties are checked on every cycle:

- Outputs change only after a boundary edge.
- In combined mode the outputs are always uniform.
- A combined or forced request drives all outputs low.
- Each per-link output follows its own sampled input.
- The captured configuration stays frozen while any output is high.

Some behaviours only the bench scenarios can show:

- The reset hold before the first boundary.
- The exact number of frames in a two-frame error pulse compared with a five-frame reinitialization request.
- A disabled link that is ignored in combined mode.
- A mode change requested while outputs are high, which takes effect only after the outputs next go low.

// File: rtl/sync_comb_pkg.sv
package sync_comb_pkg;

   typedef struct packed {
      logic comb;
      logic no_dl;
   } sync_mode_t;

   localparam sync_mode_t SYNC_MODE_RESET = '{comb: 1'b1, no_dl: 1'b0};

   localparam int unsigned SYNC_MAX_LINKS = 64;

endpackage

// File: rtl/sync_cfg_latch.sv
module sync_cfg_latch
   import sync_comb_pkg::*;
#(
   parameter int unsigned N_LINKS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_i,
   input  logic               mode_comb_i,
   input  logic               no_dl_i,
   input  logic [N_LINKS-1:0] en_i,
   output logic               comb_eff_o,
   output logic               no_dl_o,
   output logic [N_LINKS-1:0] en_o
);

   sync_mode_t               mode_q;
   logic [N_LINKS-1:0]       en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SYNC_MODE_RESET;
         en_q   <= '1;
      end else if (open_i) begin
         mode_q <= '{comb: mode_comb_i, no_dl: no_dl_i};
         en_q   <= en_i;
      end
   end

   assign comb_eff_o = mode_q.comb | mode_q.no_dl;
   assign no_dl_o    = mode_q.no_dl;
   assign en_o       = en_q;

endmodule

// File: rtl/sync_link_gate.sv
module sync_link_gate #(
   parameter int unsigned N_LINKS = 4
) (
   input  logic [N_LINKS-1:0] req_n_i,
   input  logic [N_LINKS-1:0] en_i,
   output logic [N_LINKS-1:0] req_o,
   output logic               any_o
);

   for (genvar g = 0; g < N_LINKS; g++) begin : g_link
      assign req_o[g] = en_i[g] & ~req_n_i[g];
   end

   assign any_o = |req_o;

endmodule

// File: rtl/sync_out_stage.sv
module sync_out_stage #(
   parameter int unsigned N_LINKS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               comb_i,
   input  logic               any_i,
   input  logic [N_LINKS-1:0] req_i,
   output logic [N_LINKS-1:0] sync_n_o
);

   for (genvar g = 0; g < N_LINKS; g++) begin : g_out
      logic nxt;
      assign nxt = comb_i ? ~any_i : ~req_i[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_n_o[g] <= 1'b0;
         end else if (tick_i) begin
            sync_n_o[g] <= nxt;
         end
      end
   end

endmodule

// File: rtl/sync_req_combiner.sv
module sync_req_combiner
   import sync_comb_pkg::*;
#(
   parameter int unsigned N_LINKS         = 4,
   parameter bit          LAUNCH_ON_FRAME = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_tick,
   input  logic               mode_comb,
   input  logic               no_dl,
   input  logic [N_LINKS-1:0] link_en,
   input  logic [N_LINKS-1:0] link_req_n,
   output logic [N_LINKS-1:0] sync_n
);

   if (N_LINKS < 1 || N_LINKS > SYNC_MAX_LINKS) begin : g_bad_links
      $error("sync_req_combiner: N_LINKS out of range");
   end

   logic               tick;
   logic               all_low;
   logic               comb_eff;
   logic               cfg_no_dl;
   logic [N_LINKS-1:0] cfg_en;
   logic [N_LINKS-1:0] req_act;
   logic               any_req;

   assign tick    = frame_tick | LAUNCH_ON_FRAME;
   assign all_low = ~|sync_n;

   sync_cfg_latch #(.N_LINKS(N_LINKS)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_i      (all_low),
      .mode_comb_i (mode_comb),
      .no_dl_i     (no_dl),
      .en_i        (link_en),
      .comb_eff_o  (comb_eff),
      .no_dl_o     (cfg_no_dl),
      .en_o        (cfg_en)
   );

   sync_link_gate #(.N_LINKS(N_LINKS)) u_gate (
      .req_n_i (link_req_n),
      .en_i    (cfg_en),
      .req_o   (req_act),
      .any_o   (any_req)
   );

   sync_out_stage #(.N_LINKS(N_LINKS)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .comb_i   (comb_eff),
      .any_i    (any_req),
      .req_i    (req_act),
      .sync_n_o (sync_n)
   );

endmodule

// File: rtl/sync_req_combiner_chk.sv
module sync_req_combiner_chk #(
   parameter int unsigned N_LINKS         = 4,
   parameter bit          LAUNCH_ON_FRAME = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_tick,
   input logic [N_LINKS-1:0] link_req_n,
   input logic [N_LINKS-1:0] sync_n,
   input logic               comb_eff,
   input logic               cfg_no_dl,
   input logic [N_LINKS-1:0] cfg_en
);

   logic edge_ok;
   logic any_in;
   assign edge_ok = frame_tick | LAUNCH_ON_FRAME;
   assign any_in  = |(cfg_en & ~link_req_n);

   assert_change_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sync_n) |-> $past(edge_ok));

   assert_comb_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(edge_ok && comb_eff && any_in) |-> (sync_n == '0));

   assert_comb_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
      comb_eff |-> (sync_n == '0 || sync_n == '1));

   for (genvar g = 0; g < N_LINKS; g++) begin : g_chk
      assert_perlink_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(edge_ok && !comb_eff) |-> (sync_n[g] == $past(link_req_n[g] | ~cfg_en[g])));
   end

   assert_force_comb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(edge_ok && cfg_no_dl && any_in) |-> (sync_n == '0));

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_n != '0) |-> $stable({comb_eff, cfg_no_dl, cfg_en}));

endmodule

bind sync_req_combiner sync_req_combiner_chk #(
   .N_LINKS         (N_LINKS),
   .LAUNCH_ON_FRAME (LAUNCH_ON_FRAME)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .link_req_n (link_req_n),
   .sync_n     (sync_n),
   .comb_eff   (comb_eff),
   .cfg_no_dl  (cfg_no_dl),
   .cfg_en     (cfg_en)
);

// File: tb/test_sync_req_combiner.sv
module test_sync_req_combiner;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_tick = 1'b0;
   logic         mode_comb = 1'b1;
   logic         no_dl = 1'b0;
   logic [N-1:0] link_en = '1;
   logic [N-1:0] link_req_n = '1;
   logic [N-1:0] sync_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sync_req_combiner #(.N_LINKS(N), .LAUNCH_ON_FRAME(1'b0)) i_sync_req_combiner (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .mode_comb  (mode_comb),
      .no_dl      (no_dl),
      .link_en    (link_en),
      .link_req_n (link_req_n),
      .sync_n     (sync_n)
   );

   // row: {req id[3:0], comb, no_dl, en[3:0], req_n[3:0], expected[3:0]}
   localparam int ROWS = 14;
   localparam logic [17:0] VEC [ROWS] = '{
      {4'd4, 1'b1, 1'b0, 4'hF, 4'hF, 4'hF},
      {4'd3, 1'b1, 1'b0, 4'hF, 4'hE, 4'h0},
      {4'd4, 1'b1, 1'b0, 4'hF, 4'hF, 4'hF},
      {4'd7, 1'b0, 1'b0, 4'hF, 4'hE, 4'h0},
      {4'd5, 1'b0, 1'b0, 4'hF, 4'hE, 4'hE},
      {4'd5, 1'b0, 1'b0, 4'hF, 4'hB, 4'hB},
      {4'd5, 1'b0, 1'b0, 4'hF, 4'h5, 4'h5},
      {4'd5, 1'b0, 1'b0, 4'hF, 4'hF, 4'hF},
      {4'd5, 1'b0, 1'b1, 4'hF, 4'h0, 4'h0},
      {4'd6, 1'b0, 1'b1, 4'hF, 4'h7, 4'h0},
      {4'd6, 1'b0, 1'b1, 4'hF, 4'hF, 4'hF},
      {4'd7, 1'b0, 1'b0, 4'hF, 4'h0, 4'h0},
      {4'd8, 1'b0, 1'b0, 4'hE, 4'h0, 4'h1},
      {4'd8, 1'b0, 1'b0, 4'hE, 4'hE, 4'hF}
   };

   function automatic string rname(input logic [3:0] id);
      case (id)
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [N-1:0] exp);
      checks++;
      if (sync_n !== exp) begin
         errors++;
         $display("FAIL %s: sync_n=%b expected %b", tag, sync_n, exp);
      end
   endtask

   // inputs set, one capture edge, then one boundary edge; returns at the negedge after it
   task automatic frame(input logic c, input logic d, input logic [N-1:0] e, input logic [N-1:0] r);
      @(negedge clk);
      mode_comb  = c;
      no_dl      = d;
      link_en    = e;
      link_req_n = r;
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state, held low with inputs high and no boundary
      repeat (3) @(negedge clk);
      check("R1 in reset", 4'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset, no boundary yet", 4'h0);

      for (int i = 0; i < ROWS; i++) begin
         frame(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4]);
         check($sformatf("%s row %0d", rname(VEC[i][17:14]), i), VEC[i][3:0]);
      end

      // R2: input change without a boundary leaves outputs unchanged
      @(negedge clk);
      link_req_n = 4'hB;
      repeat (3) @(negedge clk);
      check("R2 no boundary", 4'hF);
      frame(1'b0, 1'b0, 4'hE, 4'hB);
      check("R2 boundary applies", 4'hB);

      // R1/R8: fresh reset with combined mode and link0 disabled
      @(negedge clk);
      rst_n = 1'b0;
      mode_comb = 1'b1; no_dl = 1'b0; link_en = 4'hE; link_req_n = 4'hE;
      @(negedge clk);
      check("R1 reset clears outputs", 4'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 held low before boundary", 4'h0);
      frame(1'b1, 1'b0, 4'hE, 4'hE);
      check("R8 disabled link ignored in combined mode", 4'hF);
      frame(1'b1, 1'b0, 4'hE, 4'hD);
      check("R3 enabled link request", 4'h0);
      frame(1'b1, 1'b0, 4'hE, 4'hF);
      check("R4 common release", 4'hF);

      // R9: two-frame error pulse, combined
      frame(1'b1, 1'b0, 4'hF, 4'hB);
      check("R9 error frame 1", 4'h0);
      frame(1'b1, 1'b0, 4'hF, 4'hB);
      check("R9 error frame 2", 4'h0);
      frame(1'b1, 1'b0, 4'hF, 4'hF);
      check("R9 error not stretched", 4'hF);

      // R9: five-frame reinitialization request, combined
      for (int k = 0; k < 5; k++) begin
         frame(1'b1, 1'b0, 4'hF, 4'h7);
         check($sformatf("R9 reinit frame %0d", k + 1), 4'h0);
      end
      frame(1'b1, 1'b0, 4'hF, 4'hF);
      check("R9 reinit released", 4'hF);

      // R9: per-link two-frame pulse stays on its own link
      frame(1'b0, 1'b0, 4'hF, 4'h0);
      check("R7 switch blocked while high", 4'h0);
      frame(1'b0, 1'b0, 4'hF, 4'hF);
      check("R5 per-link release", 4'hF);
      frame(1'b0, 1'b0, 4'hF, 4'hD);
      check("R9 per-link pulse frame 1", 4'hD);
      frame(1'b0, 1'b0, 4'hF, 4'hD);
      check("R9 per-link pulse frame 2", 4'hD);
      frame(1'b0, 1'b0, 4'hF, 4'hF);
      check("R9 per-link pulse ends", 4'hF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule